// File: doc/BRIEF.md
# DMA Address and Count Register Unit

This block holds the software-visible setup of a simple word-oriented DMA engine. It keeps a 14-bit transfer count, a direction flag and an enable flag. All three are written in one access to a count register in the I/O zone. It also keeps a 22-bit DMA byte address that is loaded in an unusual way. The value comes from the CPU address lines, not the data bus. The write lands in one of two halves of an address window, and CPU address bit 14 picks the half.

When the transfer engine finishes a word, it pulses `xferDone`. While DMA is enabled, each pulse advances the count by one and the address by two bytes. When the count wraps past its maximum, a sticky terminal flag is set. A count write with the direction bit clear issues a one-cycle dummy-transfer request. Reading the count register returns the count with its two top bits forced high.

Top module: `dma_reg_unit`

## Requirements
- R1: A write to the count register (CPU address bits 23:22 = 01, bits 19:16 = 0x6) stores data bits 15, 14 and 13:0 as enable, direction and count base. The outputs show them in the cycle after the write edge.
- R2: Every count write leaves the count at the written 14-bit value plus one, modulo 2^14.
- R3: `dummyReq` is high for exactly the one cycle after a count write whose data bit 14 is 0. It is low at all other times.
- R4: When `cpuRd` is high and the address selects the count register, `rdData` combinationally shows `{2'b11, count}`.
- R5: A write to the address window (bits 23:22 = 01, bits 19:16 = 0xD) with CPU address bit 14 = 1 loads DMA address bits 21:9 from CPU address bits 13:1. DMA address bits 8:1 keep their value.
- R6: A window write with CPU address bit 14 = 0 loads DMA address bits 8:1 from CPU address bits 8:1. DMA address bits 21:9 keep their value, and CPU address bits 13:9 are ignored.
- R7: DMA address bit 0 always reads 0, including when CPU address bit 0 is 1 during a window write.
- R8: While enable is 1, each `xferDone` pulse advances the count by one and the DMA address by 2, with the address wrapping at 2^22.
- R9: While enable is 0, `xferDone` changes neither the count nor the address.
- R10: `countTerm` is set when a transfer step advances the count from 0x3FFF to 0. It stays set until the next count write, which clears it.
- R11: A count write in the same cycle as `xferDone` takes the written value plus one and drops the step. A window write in the same cycle as a step loads the address and drops that cycle's address increment, while the count still steps.
- R12: Writes to any other region or zone change no register.
- R13: `rdData` is 0 unless a read selects the count register.
- R14: After reset, every register is 0, DMA is disabled and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 24 | CPU address bus |
| cpuData | input | 16 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, one cycle per access |
| cpuRd | input | 1 | CPU read strobe |
| xferDone | input | 1 | Word-transfer-complete pulse from the engine |
| rdData | output | 16 | Read data for the count register |
| dmaAddr | output | 22 | Current DMA byte address, bit 0 always 0 |
| dmaCount | output | 14 | Current transfer count |
| dmaDirFlag | output | 1 | Direction flag as written |
| dmaEnable | output | 1 | DMA enable |
| dummyReq | output | 1 | One-cycle dummy-transfer request |
| countTerm | output | 1 | Sticky count-wrap flag |

## Verification
Some relations are checked by assertions on every cycle:
- the count value after a count write;
- the origin of every dummy request;
- the address half that a window write must preserve;
- count and address stability while disabled;
- the two-byte address step;
- the single cause of the terminal flag.

Other behaviour can only be shown by the bench's scenarios:
- the read-back format;
- the decode of zone and region, including writes elsewhere being ignored;
- the full sweeps over every high-half address value and over count data patterns;
- the write-versus-step priority in shared cycles.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;

  // Strobes passed from the decode/control block to the register datapath.
  typedef struct packed {
    logic cntLoad;     // count register write
    logic addrHiLoad;  // address window write, upper half
    logic addrLoLoad;  // address window write, lower half
    logic xferStep;    // accepted transfer step
    logic cntRead;     // count register read
  } regStrobes_t;

endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_reg_pkg::*;
#(
  parameter int ZONE_W       = 2,
  parameter int ZONE_VAL     = 1,
  parameter int REGION_W     = 4,
  parameter int COUNT_REGION = 6,
  parameter int ADDR_REGION  = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ZONE_W-1:0]   zoneBits,
  input  logic [REGION_W-1:0] regionBits,
  input  logic                halfSel,
  input  logic                cpuWr,
  input  logic                cpuRd,
  input  logic                xferDone,
  input  logic                dmaEnable,
  output regStrobes_t         strb
);

  localparam logic [ZONE_W-1:0]   ZoneMatch  = ZONE_W'(ZONE_VAL);
  localparam logic [REGION_W-1:0] CountMatch = REGION_W'(COUNT_REGION);
  localparam logic [REGION_W-1:0] AddrMatch  = REGION_W'(ADDR_REGION);

  logic inZone;
  logic selCount;
  logic selAddr;

  always_comb begin
    inZone   = (zoneBits == ZoneMatch);
    selCount = inZone && (regionBits == CountMatch);
    selAddr  = inZone && (regionBits == AddrMatch);

    strb.cntLoad    = cpuWr && selCount;
    strb.addrHiLoad = cpuWr && selAddr && halfSel;
    strb.addrLoLoad = cpuWr && selAddr && !halfSel;
    strb.cntRead    = cpuRd && selCount;
    // a count write overrides a simultaneous transfer step
    strb.xferStep   = xferDone && dmaEnable && !strb.cntLoad;
  end

  // R9
  no_step_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |-> !strb.xferStep);

  // R11
  write_beats_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && selCount && xferDone) |-> !strb.xferStep);

endmodule

// File: rtl/dma_reg_datapath.sv
module dma_reg_datapath
  import dma_reg_pkg::*;
#(
  parameter int CNT_W  = 14,
  parameter int DMA_AW = 22,
  parameter int LOW_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobes_t          strb,
  input  logic [DMA_AW-2:1]    loadBits,   // CPU address bits used for loading
  input  logic [CNT_W+1:0]     cpuData,
  output logic [CNT_W+1:0]     rdData,
  output logic [DMA_AW-1:0]    dmaAddr,
  output logic [CNT_W-1:0]     dmaCount,
  output logic                 dmaDirFlag,
  output logic                 dmaEnable,
  output logic                 dummyReq,
  output logic                 countTerm
);

  localparam int HI_W   = DMA_AW - 1 - LOW_W;
  localparam int DIR_BIT = CNT_W;
  localparam int EN_BIT  = CNT_W + 1;
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [DMA_AW-2:0] addrWord;   // byte address bits DMA_AW-1:1
  logic [CNT_W-1:0]  cntReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg     <= '0;
      dmaDirFlag <= 1'b0;
      dmaEnable  <= 1'b0;
      dummyReq   <= 1'b0;
      countTerm  <= 1'b0;
    end else begin
      dummyReq <= 1'b0;
      if (strb.cntLoad) begin
        cntReg     <= cpuData[CNT_W-1:0] + CNT_W'(1);
        dmaDirFlag <= cpuData[DIR_BIT];
        dmaEnable  <= cpuData[EN_BIT];
        dummyReq   <= !cpuData[DIR_BIT];
        countTerm  <= 1'b0;
      end else if (strb.xferStep) begin
        cntReg <= cntReg + CNT_W'(1);
        if (cntReg == CntMax) countTerm <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrWord <= '0;
    end else if (strb.addrHiLoad || strb.addrLoLoad) begin
      if (strb.addrHiLoad) addrWord[DMA_AW-2:LOW_W] <= loadBits[HI_W:1];
      if (strb.addrLoLoad) addrWord[LOW_W-1:0]      <= loadBits[LOW_W:1];
    end else if (strb.xferStep) begin
      addrWord <= addrWord + (DMA_AW-1)'(1);
    end
  end

  always_comb begin
    dmaAddr  = {addrWord, 1'b0};
    dmaCount = cntReg;
    rdData   = strb.cntRead ? {2'b11, cntReg} : '0;
  end

  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> dmaCount == ($past(cpuData[CNT_W-1:0]) + CNT_W'(1)));

  // R3
  dummy_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    dummyReq |-> ($past(strb.cntLoad) && !$past(cpuData[DIR_BIT])));

  // R5
  hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrHiLoad && !strb.addrLoLoad) |=> dmaAddr[LOW_W:1] == $past(dmaAddr[LOW_W:1]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEnable && !strb.cntLoad && !strb.addrHiLoad && !strb.addrLoLoad)
      |=> ($stable(dmaCount) && $stable(dmaAddr)));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xferStep && !strb.addrHiLoad && !strb.addrLoLoad)
      |=> dmaAddr == ($past(dmaAddr) + DMA_AW'(2)));

  // R10
  term_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countTerm) |-> ($past(strb.xferStep) && $past(dmaCount) == CntMax));

endmodule

// File: rtl/dma_reg_unit.sv
module dma_reg_unit
  import dma_reg_pkg::*;
#(
  parameter int CPU_AW       = 24,
  parameter int CNT_W        = 14,
  parameter int DMA_AW       = 22,
  parameter int LOW_W        = 8,
  parameter int ZONE_VAL     = 1,
  parameter int COUNT_REGION = 6,
  parameter int ADDR_REGION  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [CNT_W+1:0]  cpuData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic              xferDone,
  output logic [CNT_W+1:0]  rdData,
  output logic [DMA_AW-1:0] dmaAddr,
  output logic [CNT_W-1:0]  dmaCount,
  output logic              dmaDirFlag,
  output logic              dmaEnable,
  output logic              dummyReq,
  output logic              countTerm
);

  localparam int ZONE_W     = 2;
  localparam int REGION_W   = 4;
  localparam int REGION_LSB = 16;
  localparam int HALF_BIT   = 14;

  regStrobes_t strb;
  logic unusedAddrBits;

  assign unusedAddrBits = ^{cpuAddr[CPU_AW-ZONE_W-1:REGION_LSB+REGION_W],
                            cpuAddr[REGION_LSB-1:HALF_BIT+1], cpuAddr[0]};

  dma_reg_ctrl #(
    .ZONE_W(ZONE_W), .ZONE_VAL(ZONE_VAL), .REGION_W(REGION_W),
    .COUNT_REGION(COUNT_REGION), .ADDR_REGION(ADDR_REGION)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .zoneBits(cpuAddr[CPU_AW-1:CPU_AW-ZONE_W]),
    .regionBits(cpuAddr[REGION_LSB+REGION_W-1:REGION_LSB]),
    .halfSel(cpuAddr[HALF_BIT]),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .xferDone(xferDone),
    .dmaEnable(dmaEnable), .strb(strb)
  );

  dma_reg_datapath #(
    .CNT_W(CNT_W), .DMA_AW(DMA_AW), .LOW_W(LOW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadBits(cpuAddr[DMA_AW-2:1]), .cpuData(cpuData),
    .rdData(rdData), .dmaAddr(dmaAddr), .dmaCount(dmaCount),
    .dmaDirFlag(dmaDirFlag), .dmaEnable(dmaEnable),
    .dummyReq(dummyReq), .countTerm(countTerm)
  );

endmodule

// File: tb/dma_reg_unit_bench.sv
module dma_reg_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] CNT_A = 24'h460000;
  localparam logic [23:0] WIN_A = 24'h4D0000;

  logic clk = 0, rstN = 0;
  logic [23:0] cpuAddr = '0;
  logic [15:0] cpuData = '0;
  logic cpuWr = 0, cpuRd = 0, xferDone = 0;
  logic [15:0] rdData;
  logic [21:0] dmaAddr;
  logic [13:0] dmaCount;
  logic dmaDirFlag, dmaEnable, dummyReq, countTerm;

  int total = 0, bad = 0;
  logic [13:0] eCnt = '0;
  logic [21:0] eAddr = '0;
  logic eDir = 0, eEn = 0, eTerm = 0, eDummy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reg_unit u_dma_reg_unit (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .xferDone(xferDone), .rdData(rdData),
    .dmaAddr(dmaAddr), .dmaCount(dmaCount), .dmaDirFlag(dmaDirFlag),
    .dmaEnable(dmaEnable), .dummyReq(dummyReq), .countTerm(countTerm)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(tag, "count", dmaCount, eCnt);
    chk(tag, "addr", dmaAddr, eAddr);
    chk(tag, "dir", dmaDirFlag, eDir);
    chk(tag, "enable", dmaEnable, eEn);
    chk(tag, "dummy", dummyReq, eDummy);
    chk(tag, "term", countTerm, eTerm);
  endtask

  // one bus cycle, started and finished at a falling edge
  task automatic op(input logic [23:0] a, input logic [15:0] d, input logic w, input logic x);
    cpuAddr = a; cpuData = d; cpuWr = w; xferDone = x;
    @(negedge clk);
    cpuWr = 0; xferDone = 0;
  endtask

  task automatic modelStep();
    if (eEn) begin
      if (eCnt == 14'h3FFF) eTerm = 1;
      eCnt = eCnt + 14'd1;
      eAddr = eAddr + 22'd2;
    end
  endtask

  task automatic wrCount(input logic [15:0] d, input string tag);
    op(CNT_A, d, 1, 0);
    eCnt = d[13:0] + 14'd1; eDir = d[14]; eEn = d[15]; eTerm = 0; eDummy = !d[14];
    chkAll(tag);
    eDummy = 0;
  endtask

  task automatic readCount(input string tag);
    cpuAddr = CNT_A; cpuRd = 1; #1;
    chk(tag, "readback", rdData, {2'b11, eCnt});
    cpuRd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chkAll("R14");
    chk("R13", "rdData idle", rdData, 0);
    rstN = 1;
    @(negedge clk);

    // R1 R2 R3 R4: sweep count-register data patterns
    for (int v = 0; v < 65536; v += 257) wrCount(16'(v), "R1");
    wrCount(16'h3FFF, "R2");
    readCount("R4");
    wrCount(16'hFFFF, "R2");
    readCount("R4");
    wrCount(16'h4123, "R3");
    op(24'h0, 16'h0, 0, 0);
    chk("R3", "dummy single cycle", dummyReq, 0);

    // R5: every high-half value
    for (int i = 0; i < 8192; i++) begin
      op(WIN_A | 24'h004000 | 24'(i << 1), 16'h0, 1, 0);
      eAddr[21:9] = 13'(i);
      chk("R5", "addr hi", dmaAddr, eAddr);
    end
    // R6 R7: every low-half value with junk in bits 13:9 and bit 0
    for (int i = 0; i < 256; i++) begin
      op(WIN_A | 24'(((i * 37) & 31) << 9) | 24'(i << 1) | 24'(i & 1), 16'h0, 1, 0);
      eAddr[8:1] = 8'(i);
      chk("R6", "addr lo", dmaAddr, eAddr);
      chk("R7", "addr bit0", dmaAddr[0], 0);
    end

    // R8 R10: stepping through the wrap
    op(WIN_A | 24'h007FFE, 16'h0, 1, 0); eAddr[21:9] = 13'h1FFF; chkAll("R8");
    op(WIN_A | 24'h0001FC, 16'h0, 1, 0); eAddr[8:1] = 8'hFE; chkAll("R8");
    wrCount(16'hBFFC, "R1");
    for (int k = 0; k < 6; k++) begin
      op(24'h0, 16'h0, 0, 1);
      modelStep();
      chkAll("R10");
    end
    readCount("R4");
    wrCount(16'h8010, "R10");   // term clears on write

    // R9: disabled steps ignored
    wrCount(16'h4005, "R9");
    for (int k = 0; k < 4; k++) begin
      op(24'h0, 16'h0, 0, 1);
      chkAll("R9");
    end

    // R11: write vs step in one cycle
    wrCount(16'h8100, "R11");
    op(CNT_A, 16'hC200, 1, 1);
    eCnt = 14'h0201; eDir = 1; eEn = 1; eDummy = 0;
    chkAll("R11");
    op(WIN_A | 24'h000020, 16'h0, 1, 1);
    eCnt = eCnt + 14'd1; eAddr[8:1] = 8'h10;
    chkAll("R11");

    // R12: other regions and zones ignored
    op(24'h450000, 16'h0123, 1, 0); chkAll("R12");
    op(24'h060000, 16'h0123, 1, 0); chkAll("R12");
    op(24'hCD4000, 16'h0, 1, 0);    chkAll("R12");
    cpuAddr = WIN_A; cpuRd = 1; #1;
    chk("R13", "rdData other region", rdData, 0);
    cpuRd = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule